// File: doc/BRIEF.md
# NAND Flash Section-Mapped Bus Bridge

This block connects a simple memory-mapped host bus to an 8-bit asynchronous NAND flash device. The host does not program a cycle type. It picks the NAND cycle by the address window it touches. A write into the command window becomes a command-latch cycle. A write into the address window becomes an address-latch cycle. Reads and writes in the data window become plain data cycles. A multi-byte flash address is sent as a run of single-byte writes to the address window. The data window needs no incrementing address, because the flash steps its own column pointer.

The NAND region holds two 64 MB spaces, common and attribute. Each space has its own programmable timing set: setup, strobe width, hold and bus turn-around. The bridge applies the set that belongs to the space being accessed. It holds the host in wait (ready low) for the whole cycle. A read from the command or address window returns zero with an error flag and issues no strobe.

Top module: `nand_bridge`

## Requirements
- R1: An access is claimed (`hostClaim`=1) only for addresses 0x8000_0000–0x83FF_FFFF (common) and 0x8800_0000–0x8BFF_FFFF (attribute). A request to any other address starts no cycle, and `hostReady` stays high.
- R2: Address bits [17:16] pick the window: 00 is data, 01 is command, and 10 or 11 is address. All other bits inside a space have no effect on the cycle.
- R3: A write to the command window drives the byte on `nandDout` with `nandCle`=1 and `nandAle`=0 for the whole cycle.
- R4: Each write to the address window drives its byte with `nandAle`=1 and `nandCle`=0. Back-to-back writes give one latch cycle each, in order.
- R5: Data-window cycles keep `nandCle`=`nandAle`=0. A data read returns the `nandDin` value present on the last clock with `nandReN` low.
- R6: Common-space accesses use timing set 0. Attribute-space accesses use timing set 1.
- R7: With field values S (setup), W (wait) and H (hold), `nandCeN` is low for S+W+H+3 clocks. `nandWeN` (write) or `nandReN` (read) goes low S+1 clocks after `nandCeN` falls and stays low W+1 clocks. The two strobes are never low together.
- R8: `nandDoe` is high only in write cycles. It rises Z+1 clocks after `nandCeN` falls (Z = high-Z field) and drops when `nandCeN` rises.
- R9: `hostReady` is high only when idle. It goes low on the clock after a request is accepted and returns high when the hold phase ends. A request made while `hostReady` is low is ignored.
- R10: A read from the command or address window sets `hostErr`=1 and `hostRdata`=0 on the next clock, keeps `hostReady` high and leaves `nandCeN` high. The next accepted normal access clears `hostErr`.
- R11: A config write (`cfgWe`=1) loads set `cfgSel` (0 common, 1 attribute) from `cfgData`, with the fields laid out as [7:0] setup, [15:8] wait, [23:16] hold and [31:24] high-Z. After reset both sets hold the parameter `RESET_TIMING` (default setup 1, wait 2, hold 1, high-Z 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | One-clock access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 32 | Host byte address |
| hostWdata | input | 8 | Write byte |
| hostReady | output | 1 | Bridge idle and able to accept |
| hostClaim | output | 1 | Current address lies in a NAND space |
| hostRdata | output | 8 | Read result |
| hostErr | output | 1 | Last access was an illegal read |
| cfgWe | input | 1 | Timing set write strobe |
| cfgSel | input | 1 | Timing set select |
| cfgData | input | 32 | Timing fields |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Byte driven to flash |
| nandDoe | output | 1 | Output enable for `nandDout` |
| nandDin | input | 8 | Byte from flash |

## Verification
The assertions assume the host pulses `hostReq` for a single clock and only while `hostReady` is high. The one exception is a deliberate request during a busy cycle, which must be ignored. They also assume timing sets are not rewritten while a cycle runs. The stimulus keeps to this rule: every configuration write happens while the bridge is idle, and each request lasts exactly one clock. A behavioural flash stub returns a stepping read byte and logs each latched (CLE, ALE, byte) triple. Every pin is compared on each clock against a reference that is worked out from the programmed field values.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  localparam int FIELD_W = 8;
  localparam int CFG_W   = 4 * FIELD_W;
  localparam int SPACES  = 2;

  typedef enum logic [1:0] {
    SEC_DATA = 2'd0,
    SEC_CMD  = 2'd1,
    SEC_ADDR = 2'd2
  } section_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Packed so that field order matches the config word: hiZ is the MSB byte.
  typedef struct packed {
    logic [FIELD_W-1:0] hiZ;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] waitLen;
    logic [FIELD_W-1:0] setup;
  } timing_t;

  typedef struct packed {
    logic latchReq;   // request accepted, capture its attributes
    logic errResp;    // illegal read answered at once
    logic capture;    // sample flash data this edge
    logic active;     // a flash cycle is in progress
    logic strobeLow;  // WE#/RE# phase
    logic driveEn;    // write data may be driven
  } ctrl_strobe_t;

endpackage

// File: rtl/nand_bridge_decode.sv
module nand_bridge_decode
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPACE_BITS = 26,
  parameter int SECTION_LSB = 16,
  parameter logic [ADDR_W-1:0] COMMON_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] ATTR_BASE   = 32'h8800_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              claim,
  output logic              attr,
  output section_e          section
);

  localparam int TAG_W = ADDR_W - SPACE_BITS;

  logic [TAG_W-1:0] tag;
  logic             inCommon;
  logic             inAttr;
  logic [1:0]       secBits;
  logic             unusedAddrBits;

  assign tag      = addr[ADDR_W-1:SPACE_BITS];
  assign inCommon = (tag == COMMON_BASE[ADDR_W-1:SPACE_BITS]);
  assign inAttr   = (tag == ATTR_BASE[ADDR_W-1:SPACE_BITS]);
  assign claim    = inCommon | inAttr;
  assign attr     = inAttr;
  assign secBits  = addr[SECTION_LSB+1:SECTION_LSB];

  // Offsets inside a window and bits above the section field carry no meaning.
  assign unusedAddrBits = ^{addr[SPACE_BITS-1:SECTION_LSB+2], addr[SECTION_LSB-1:0]};

  always_comb begin
    unique case (secBits)
      2'b00:   section = SEC_DATA;
      2'b01:   section = SEC_CMD;
      default: section = SEC_ADDR;
    endcase
  end

endmodule

// File: rtl/nand_bridge_ctrl.sv
module nand_bridge_ctrl
  import nand_bridge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostReq,
  input  logic         hostWrite,
  input  logic         claim,
  input  section_e     section,
  input  timing_t      timing,
  output logic         hostReady,
  output ctrl_strobe_t strobes
);

  phase_e             phase;
  logic [FIELD_W-1:0] phaseCnt;
  logic [FIELD_W-1:0] hizLeft;
  logic               hizDone;
  logic               isWrite;
  logic               accept;
  logic               errRead;
  logic               start;
  logic               cntZero;

  assign accept  = hostReq && (phase == PH_IDLE) && claim;
  assign errRead = accept && !hostWrite && (section != SEC_DATA);
  assign start   = accept && !errRead;
  assign cntZero = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_SETUP;
            phaseCnt <= timing.setup;
            isWrite  <= hostWrite;
          end
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase    <= PH_STROBE;
            phaseCnt <= timing.waitLen;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cntZero) begin
            phase    <= PH_HOLD;
            phaseCnt <= timing.hold;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cntZero) phase <= PH_IDLE;
          else         phaseCnt <= phaseCnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Bus turn-around counter runs from the first setup clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hizLeft <= '0;
      hizDone <= 1'b0;
    end else if (start) begin
      hizLeft <= timing.hiZ;
      hizDone <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (hizLeft == '0) hizDone <= 1'b1;
      else               hizLeft <= hizLeft - 1'b1;
    end
  end

  assign hostReady         = (phase == PH_IDLE);
  assign strobes.latchReq  = start;
  assign strobes.errResp   = errRead;
  assign strobes.active    = (phase != PH_IDLE);
  assign strobes.strobeLow = (phase == PH_STROBE);
  assign strobes.capture   = (phase == PH_STROBE) && cntZero && !isWrite;
  assign strobes.driveEn   = (phase != PH_IDLE) && isWrite && hizDone;

endmodule

// File: rtl/nand_bridge_datapath.sv
module nand_bridge_datapath
  import nand_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [CFG_W-1:0] RESET_TIMING = 32'h0001_0201
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic              attrNow,
  input  section_e          sectionNow,
  input  logic              hostWrite,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [DATA_W-1:0] nandDin,
  output timing_t           timing,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDout,
  output logic              nandDoe
);

  timing_t           timingRegs [SPACES];
  logic              reqAttr;
  section_e          reqSection;
  logic              reqWrite;
  logic [DATA_W-1:0] reqByte;
  logic              selAttr;

  for (genvar s = 0; s < SPACES; s++) begin : g_space
    timing_t regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        regQ <= timing_t'(RESET_TIMING);
      else if (cfgWe && cfgSel == 1'(s)) regQ <= timing_t'(cfgData);
    end
    assign timingRegs[s] = regQ;
  end

  // While idle the set follows the address on the bus; during a cycle it is pinned.
  assign selAttr = strobes.active ? reqAttr : attrNow;
  assign timing  = timingRegs[selAttr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAttr    <= 1'b0;
      reqSection <= SEC_DATA;
      reqWrite   <= 1'b0;
      reqByte    <= '0;
    end else if (strobes.latchReq) begin
      reqAttr    <= attrNow;
      reqSection <= sectionNow;
      reqWrite   <= hostWrite;
      reqByte    <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
      hostErr   <= 1'b0;
    end else begin
      if (strobes.errResp) begin
        hostRdata <= '0;
        hostErr   <= 1'b1;
      end else if (strobes.latchReq) begin
        hostErr   <= 1'b0;
      end
      if (strobes.capture) hostRdata <= nandDin;
    end
  end

  assign nandCeN  = !strobes.active;
  assign nandCle  = strobes.active && (reqSection == SEC_CMD);
  assign nandAle  = strobes.active && (reqSection == SEC_ADDR);
  assign nandWeN  = !(strobes.strobeLow && reqWrite);
  assign nandReN  = !(strobes.strobeLow && !reqWrite);
  assign nandDout = reqByte;
  assign nandDoe  = strobes.driveEn;

endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter logic [CFG_W-1:0] RESET_TIMING = 32'h0001_0201
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic              hostClaim,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDout,
  output logic              nandDoe,
  input  logic [DATA_W-1:0] nandDin
);

  logic         attrNow;
  section_e     sectionNow;
  timing_t      timing;
  ctrl_strobe_t strobes;

  nand_bridge_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr    (hostAddr),
    .claim   (hostClaim),
    .attr    (attrNow),
    .section (sectionNow)
  );

  nand_bridge_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .claim     (hostClaim),
    .section   (sectionNow),
    .timing    (timing),
    .hostReady (hostReady),
    .strobes   (strobes)
  );

  nand_bridge_datapath #(.DATA_W(DATA_W), .RESET_TIMING(RESET_TIMING)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .attrNow    (attrNow),
    .sectionNow (sectionNow),
    .hostWrite  (hostWrite),
    .hostWdata  (hostWdata),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .cfgData    (cfgData),
    .nandDin    (nandDin),
    .timing     (timing),
    .hostRdata  (hostRdata),
    .hostErr    (hostErr),
    .nandCeN    (nandCeN),
    .nandCle    (nandCle),
    .nandAle    (nandAle),
    .nandWeN    (nandWeN),
    .nandReN    (nandReN),
    .nandDout   (nandDout),
    .nandDoe    (nandDoe)
  );

endmodule

// File: rtl/nand_bridge_checker.sv
module nand_bridge_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostReq,
  input logic        hostWrite,
  input logic [31:0] hostAddr,
  input logic        hostReady,
  input logic        hostClaim,
  input logic [7:0]  hostRdata,
  input logic        hostErr,
  input logic        nandCeN,
  input logic        nandCle,
  input logic        nandAle,
  input logic        nandWeN,
  input logic        nandReN,
  input logic [7:0]  nandDout,
  input logic        nandDoe
);

  logic unusedAddrLow;
  assign unusedAddrLow = ^{hostAddr[31:18], hostAddr[15:0]};

  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_latch_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!nandCeN && $past(!nandCeN)) |-> ($stable(nandCle) && $stable(nandAle) && $stable(nandDout)));

  assert_strobe_in_ce_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_doe_write_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    nandDoe |-> (!nandCeN && nandReN));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> nandCeN);

  assert_unclaimed_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady && !hostClaim) |=> (hostReady && nandCeN));

  assert_err_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady && hostClaim && !hostWrite && hostAddr[17:16] != 2'b00)
    |=> (hostErr && hostRdata == 8'h00 && hostReady && nandCeN));

endmodule

bind nand_bridge nand_bridge_checker i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .hostReq   (hostReq),
  .hostWrite (hostWrite),
  .hostAddr  (hostAddr),
  .hostReady (hostReady),
  .hostClaim (hostClaim),
  .hostRdata (hostRdata),
  .hostErr   (hostErr),
  .nandCeN   (nandCeN),
  .nandCle   (nandCle),
  .nandAle   (nandAle),
  .nandWeN   (nandWeN),
  .nandReN   (nandReN),
  .nandDout  (nandDout),
  .nandDoe   (nandDoe)
);

// File: tb/test_nand_bridge.sv
`timescale 1ns/1ps
module test_nand_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [31:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic        hostReady, hostClaim, hostErr;
  logic [7:0]  hostRdata;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model of both timing sets: index 0 common, 1 attribute.
  int tSetup[2] = '{1, 1};
  int tWait[2]  = '{2, 2};
  int tHold[2]  = '{1, 1};
  int tHiz[2]   = '{0, 0};
  int nReads = 0;

  logic [9:0] gotLog[$];
  logic [9:0] expLog[$];

  always #2.5 clk = ~clk;

  nand_bridge i_nand_bridge (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostClaim(hostClaim), .hostRdata(hostRdata), .hostErr(hostErr),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoe(nandDoe), .nandDin(nandDin)
  );

  // Behavioural flash stub: logs latched triples, steps its read byte per RE# pulse.
  logic       weSeen = 1'b1;
  logic       reSeen = 1'b1;
  logic [7:0] readByte = 8'h5A;
  assign nandDin = readByte;

  always @(negedge clk) begin
    if (rstN) begin
      if (!weSeen && nandWeN) gotLog.push_back({nandCle, nandAle, nandDout});
      if (!reSeen && nandReN) readByte = readByte + 8'd1;
    end
    weSeen = nandWeN;
    reSeen = nandReN;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string secTag(input logic [1:0] sec);
    if (sec == 2'b01) return "R3";
    if (sec[1])       return "R4";
    return "R5";
  endfunction

  task automatic writeCfg(input int sel, input int s, input int w, input int h, input int z);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel[0];
    cfgData = {z[7:0], h[7:0], w[7:0], s[7:0]};
    @(negedge clk);
    cfgWe = 1'b0;
    tSetup[sel] = s; tWait[sel] = w; tHold[sel] = h; tHiz[sel] = z;
  endtask

  // One host access, checked against the reference on every clock until idle.
  task automatic access(input logic [31:0] addr, input bit wr, input logic [7:0] wb, input bit poke);
    bit         inCom, inAtt, claimed;
    int         sp, total, s, w, h, z;
    logic [1:0] sec;
    logic [7:0] expRd;
    inCom = (addr >= 32'h8000_0000) && (addr <= 32'h83FF_FFFF);
    inAtt = (addr >= 32'h8800_0000) && (addr <= 32'h8BFF_FFFF);
    claimed = inCom || inAtt;
    sp = inAtt ? 1 : 0;
    sec = addr[17:16];
    s = tSetup[sp]; w = tWait[sp]; h = tHold[sp]; z = tHiz[sp];
    total = s + w + h + 3;
    expRd = 8'h5A + 8'(nReads);

    @(negedge clk);
    chk(hostReady == 1'b1, "R9", "ready before request", 32'(hostReady), 32'd1);
    hostReq = 1'b1; hostWrite = wr; hostAddr = addr; hostWdata = wb;
    #1;
    chk(hostClaim == claimed, "R1", "claim decode", 32'(hostClaim), 32'(claimed));
    @(negedge clk);
    hostReq = 1'b0;

    if (!claimed) begin
      for (int k = 0; k < 3; k++) begin
        chk(hostReady && nandCeN, "R1", "unclaimed stays idle", {hostReady, nandCeN}, 32'd3);
        @(negedge clk);
      end
      return;
    end
    if (!wr && sec != 2'b00) begin
      chk(hostErr == 1'b1 && hostRdata == 8'h00, "R10", "illegal read response",
          {hostErr, hostRdata}, 32'h100);
      chk(hostReady && nandCeN, "R10", "illegal read no strobe", {hostReady, nandCeN}, 32'd3);
      return;
    end

    if (wr) expLog.push_back({sec == 2'b01, sec[1], wb});
    for (int i = 0; i < total; i++) begin
      logic weE, reE, doeE;
      weE  = !(wr && i >= s + 1 && i <= s + w + 1);
      reE  = !(!wr && i >= s + 1 && i <= s + w + 1);
      doeE = wr && (i >= z + 1);
      chk({nandCeN, nandWeN, nandReN} == {1'b0, weE, reE}, "R7",
          $sformatf("ce/we/re cycle %0d space %0d", i, sp),
          {nandCeN, nandWeN, nandReN}, {1'b0, weE, reE});
      chk(hostReady == 1'b0, "R9", $sformatf("busy cycle %0d", i), 32'(hostReady), 32'd0);
      chk({nandCle, nandAle} == {sec == 2'b01, sec[1]}, secTag(sec),
          $sformatf("cle/ale cycle %0d", i), {nandCle, nandAle}, {sec == 2'b01, sec[1]});
      chk(nandDoe == doeE, "R8", $sformatf("doe cycle %0d", i), 32'(nandDoe), 32'(doeE));
      if (doeE) chk(nandDout == wb, secTag(sec), "write byte", nandDout, wb);
      if (poke && i == 1) begin
        hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 32'h8001_0000; hostWdata = 8'hEE;
      end else if (poke && i == 2) begin
        hostReq = 1'b0;
      end
      @(negedge clk);
    end
    chk(hostReady && nandCeN && !nandDoe, "R9", "idle after hold",
        {hostReady, nandCeN, nandDoe}, 32'd6);
    if (!wr) begin
      chk(hostRdata == expRd, "R5", "read data", hostRdata, expRd);
      chk(hostErr == 1'b0, "R10", "err cleared", 32'(hostErr), 32'd0);
      nReads++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hostReady && nandCeN && nandWeN && nandReN && !nandDoe && !hostErr, "R9",
        "reset state", {hostReady, nandCeN, nandWeN, nandReN, nandDoe, hostErr}, 32'h3C);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset timing set used before any config write.
    access(32'h8001_0000, 1'b1, 8'hFF, 1'b0);
    access(32'h8000_0004, 1'b0, 8'h00, 1'b0);

    // R6: distinct sets for common and attribute spaces.
    writeCfg(0, 1, 2, 1, 0);
    writeCfg(1, 3, 4, 0, 2);

    // R3 command, R4 five address bytes, offsets vary inside windows (R2).
    access(32'h8001_1234, 1'b1, 8'h80, 1'b0);
    access(32'h8002_0000, 1'b1, 8'h01, 1'b0);
    access(32'h8003_FFF0, 1'b1, 8'h02, 1'b0);
    access(32'h8002_8000, 1'b1, 8'h03, 1'b0);
    access(32'h8003_0001, 1'b1, 8'h04, 1'b0);
    access(32'h83F2_0000, 1'b1, 8'h05, 1'b0);

    // R5 data burst in attribute space (R6 timing set 1), with busy poke (R9).
    access(32'h8800_0000, 1'b1, 8'hA1, 1'b1);
    access(32'h8800_0000, 1'b1, 8'hA2, 1'b0);
    access(32'h8BFC_FFFF, 1'b1, 8'hA3, 1'b0);

    // Data reads in both spaces; bits above 17 ignored (R2).
    access(32'h8004_0000, 1'b0, 8'h00, 1'b0);
    access(32'h8000_0010, 1'b0, 8'h00, 1'b0);
    access(32'h8900_0000, 1'b0, 8'h00, 1'b0);

    // R10 illegal reads, then cleared by a normal read.
    access(32'h8001_0000, 1'b0, 8'h00, 1'b0);
    access(32'h8802_0000, 1'b0, 8'h00, 1'b0);
    access(32'h8000_0000, 1'b0, 8'h00, 1'b0);

    // R1 unclaimed addresses.
    access(32'h8400_0000, 1'b1, 8'h55, 1'b0);
    access(32'h87FF_FFFF, 1'b0, 8'h00, 1'b0);
    access(32'h9000_0000, 1'b1, 8'h66, 1'b0);
    access(32'h7FFF_FFFF, 1'b1, 8'h77, 1'b0);

    // R11 minimal timing, all fields zero.
    writeCfg(0, 0, 0, 0, 0);
    access(32'h8001_0000, 1'b1, 8'h70, 1'b0);
    access(32'h8000_0000, 1'b0, 8'h00, 1'b0);

    repeat (3) @(negedge clk);
    chk(gotLog.size() == expLog.size(), "R4", "latch log length", gotLog.size(), expLog.size());
    for (int k = 0; k < expLog.size() && k < gotLog.size(); k++)
      chk(gotLog[k] == expLog[k], "R4", $sformatf("latch log entry %0d", k), gotLog[k], expLog[k]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule